// File: doc/BRIEF.md
# Vector Element to Scalar Move Unit

This unit carries out the move of a single element of a 128-bit vector register into a 64-bit general register. It is given the instruction word and the contents of the source vector, checks whether the word belongs to this move class, works out the element size and position, and returns the element widened to the destination, either with zeros or with copies of its sign bit. The destination register number, a flag saying whether the destination is the 32-bit or the 64-bit view, a write enable and an undefined-instruction flag come back together one clock after issue.

The element size and the element number share one 5-bit field: the lowest set bit of the field fixes the size, and the bits above it give the element number. Which kinds of widening are allowed depends jointly on the destination width, on the signed/unsigned bit and on the element size. Any combination outside the legal set raises the undefined flag and blocks the write. The register-file write itself and any special handling of register 31 belong to the caller.

Top module: `lane_extract_unit`

## Requirements
- R1: An issued word belongs to this class only when bit 31 is 0, bits 29..21 are 001110000, bit 15 is 0, bit 14 is 0, bit 13 is 1, bit 11 is 1 and bit 10 is 1 (bit 12 is free); any other issued word reports undefined.
- R2: The size field is bits 20..16. If bit 16 is set the element is a byte numbered by bits 20..17; else if bit 17 is set it is a halfword numbered by bits 20..18; else if bit 18 is set it is a word numbered by bits 20..19; else if bit 19 is set it is a doubleword numbered by bit 20. Element n of width w is vector bits n*w+w-1 down to n*w.
- R3: With bit 12 = 1 (unsigned), a byte, halfword or word with bit 30 = 0 is zero-extended to 64 bits, and a doubleword with bit 30 = 1 is copied unchanged; every other unsigned combination is undefined.
- R4: With bit 12 = 0 (signed) and bit 30 = 1, a byte, halfword or word is sign-extended to 64 bits; a signed doubleword is undefined for either value of bit 30.
- R5: With bit 12 = 0 and bit 30 = 0, a byte or halfword is sign-extended to 32 bits and result bits 63..32 are zero; a signed word with bit 30 = 0 is undefined.
- R6: A word whose bits 19..16 are all zero is undefined.
- R7: An undefined word gives write enable 0 and a result of zero.
- R8: Results appear on the clock edge after the issue edge; the destination index equals bits 4..0 and the 64-bit flag equals bit 30 of that word; in a cycle after no issue, neither write enable nor undefined is raised.
- R9: While reset is held, write enable, undefined, result, destination index and the 64-bit flag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A word is issued this cycle |
| instr | input | 32 | Instruction word |
| vec_src | input | 128 | Source vector contents |
| out_wen | output | 1 | Destination write enable |
| out_undef | output | 1 | Undefined-instruction flag |
| out_result | output | 64 | Widened element |
| out_rd | output | 5 | Destination register index |
| out_is64 | output | 1 | 1: 64-bit destination view, 0: 32-bit view |

## Verification
Element selection and the legality check are both decided from the same 5-bit field and the same cycle, so a word can select a real element while being illegal for its signedness and width; the bench sweeps every value of the field against both signedness values and both widths over three vectors with differing sign bits, issuing back to back so a legal word is directly followed by an illegal one. Each outcome is judged against a model that derives size, element, widening and legality arithmetically, and an illegal word must show no write, a zero result, yet still the new destination index and width flag. Words that differ from a legal one in a single fixed opcode bit are issued to confirm that class matching overrides an otherwise legal size field.

// File: rtl/lx_pkg.sv
package lx_pkg;

   localparam int LX_INSN_W = 32;
   localparam int LX_RD_W   = 5;
   localparam int LX_IMM_W  = 5;
   localparam int LX_IDX_W  = LX_IMM_W - 1;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } lx_size_e;

   typedef enum logic [1:0] {
      EXT_ZERO   = 2'd0,
      EXT_SIGN64 = 2'd1,
      EXT_SIGN32 = 2'd2
   } lx_ext_e;

   typedef struct packed {
      logic                hit;
      logic                legal;
      lx_size_e            size;
      logic [LX_IDX_W-1:0] lane_idx;
      lx_ext_e             ext;
      logic                is64;
      logic [LX_RD_W-1:0]  rd;
   } lx_dec_t;

endpackage

// File: rtl/lx_decode.sv
module lx_decode
   import lx_pkg::*;
(
   input  logic [LX_INSN_W-1:0] instr_i,
   output lx_dec_t              dec_o
);

   logic [LX_IMM_W-1:0] imm5;
   logic                is_uns;
   logic                q_bit;
   logic                class_hit;
   logic                size_ok;
   logic                combo_ok;
   lx_size_e            size;
   lx_ext_e             ext;
   logic [LX_IDX_W-1:0] idx;
   logic                unused_rn;

   assign imm5      = instr_i[20:16];
   assign is_uns    = instr_i[12];
   assign q_bit     = instr_i[30];
   assign unused_rn = ^instr_i[9:5];

   assign class_hit = (instr_i[31] == 1'b0)
                   && (instr_i[29:21] == 9'b001110000)
                   && ((instr_i[15:10] & 6'b111011) == 6'b001011);

   assign size_ok = |imm5[3:0];

   always_comb begin
      if (imm5[0]) begin
         size = SZ_BYTE;
         idx  = imm5[4:1];
      end else if (imm5[1]) begin
         size = SZ_HALF;
         idx  = {1'b0, imm5[4:2]};
      end else if (imm5[2]) begin
         size = SZ_WORD;
         idx  = {2'b00, imm5[4:3]};
      end else begin
         size = SZ_DBL;
         idx  = {3'b000, imm5[4]};
      end
   end

   always_comb begin
      combo_ok = 1'b0;
      ext      = EXT_ZERO;
      if (is_uns) begin
         if (!q_bit && size != SZ_DBL) begin
            combo_ok = 1'b1;
         end else if (q_bit && size == SZ_DBL) begin
            combo_ok = 1'b1;
         end
      end else begin
         if (q_bit && size != SZ_DBL) begin
            combo_ok = 1'b1;
            ext      = EXT_SIGN64;
         end else if (!q_bit && (size == SZ_BYTE || size == SZ_HALF)) begin
            combo_ok = 1'b1;
            ext      = EXT_SIGN32;
         end
      end
   end

   assign dec_o.hit      = class_hit;
   assign dec_o.legal    = class_hit & size_ok & combo_ok;
   assign dec_o.size     = size;
   assign dec_o.lane_idx = idx;
   assign dec_o.ext      = ext;
   assign dec_o.is64     = q_bit;
   assign dec_o.rd       = instr_i[LX_RD_W-1:0];

endmodule

// File: rtl/lx_lane_mux.sv
module lx_lane_mux
   import lx_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int GPR_W = 64
) (
   input  logic [VEC_W-1:0]    vec_i,
   input  lx_size_e            size_i,
   input  logic [LX_IDX_W-1:0] idx_i,
   output logic [GPR_W-1:0]    lane_o
);

   localparam int N_SIZES = 4;

   logic [GPR_W-1:0] cand [N_SIZES];

   for (genvar s = 0; s < N_SIZES; s++) begin : g_size
      localparam int LW = 8 << s;
      localparam int NL = VEC_W / LW;
      localparam int IW = $clog2(NL);
      logic [LW-1:0] lanes [NL];
      for (genvar k = 0; k < NL; k++) begin : g_lane
         assign lanes[k] = vec_i[k*LW +: LW];
      end
      assign cand[s] = GPR_W'(lanes[idx_i[IW-1:0]]);
   end

   assign lane_o = cand[size_i];

endmodule

// File: rtl/lx_extend.sv
module lx_extend
   import lx_pkg::*;
#(
   parameter int GPR_W = 64
) (
   input  logic [GPR_W-1:0] lane_i,
   input  lx_size_e         size_i,
   input  lx_ext_e          ext_i,
   output logic [GPR_W-1:0] result_o
);

   localparam int HALF_W  = GPR_W / 2;
   localparam int N_SIZES = 4;

   logic [GPR_W-1:0] sx [N_SIZES];
   logic [GPR_W-1:0] sx_sel;

   for (genvar s = 0; s < N_SIZES; s++) begin : g_sx
      localparam int LW = 8 << s;
      assign sx[s] = GPR_W'($signed(lane_i[LW-1:0]));
   end

   assign sx_sel = sx[size_i];

   always_comb begin
      unique case (ext_i)
         EXT_SIGN64: result_o = sx_sel;
         EXT_SIGN32: result_o = {{HALF_W{1'b0}}, sx_sel[HALF_W-1:0]};
         default:    result_o = lane_i;
      endcase
   end

endmodule

// File: rtl/lane_extract_unit.sv
module lane_extract_unit
   import lx_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int GPR_W = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [LX_INSN_W-1:0] instr,
   input  logic [VEC_W-1:0]     vec_src,
   output logic                 out_wen,
   output logic                 out_undef,
   output logic [GPR_W-1:0]     out_result,
   output logic [LX_RD_W-1:0]   out_rd,
   output logic                 out_is64
);

   if (VEC_W != 128) begin : g_bad_vec
      $error("lane_extract_unit: VEC_W must be 128 to match the 5-bit size field");
   end
   if (GPR_W != 64) begin : g_bad_gpr
      $error("lane_extract_unit: GPR_W must be 64 to hold a doubleword element");
   end

   lx_dec_t          dec;
   logic [GPR_W-1:0] lane;
   logic [GPR_W-1:0] ext_res;
   logic             do_write;

   lx_decode u_dec (
      .instr_i (instr),
      .dec_o   (dec)
   );

   lx_lane_mux #(
      .VEC_W (VEC_W),
      .GPR_W (GPR_W)
   ) u_mux (
      .vec_i  (vec_src),
      .size_i (dec.size),
      .idx_i  (dec.lane_idx),
      .lane_o (lane)
   );

   lx_extend #(
      .GPR_W (GPR_W)
   ) u_ext (
      .lane_i   (lane),
      .size_i   (dec.size),
      .ext_i    (dec.ext),
      .result_o (ext_res)
   );

   assign do_write = in_valid & dec.legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_wen    <= 1'b0;
         out_undef  <= 1'b0;
         out_result <= '0;
         out_rd     <= '0;
         out_is64   <= 1'b0;
      end else begin
         out_wen    <= do_write;
         out_undef  <= in_valid & ~dec.legal;
         out_result <= do_write ? ext_res : '0;
         if (in_valid) begin
            out_rd   <= dec.rd;
            out_is64 <= dec.is64;
         end
      end
   end

endmodule

// File: rtl/lx_chk.sv
module lx_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic [31:0] instr,
   input logic        out_wen,
   input logic        out_undef,
   input logic [63:0] out_result,
   input logic [4:0]  out_rd,
   input logic        out_is64
);

   // R1
   opcode_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[31]) |=> (out_undef && !out_wen));

   // R6
   empty_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[19:16] == 4'b0000) |=> out_undef);

   // R4
   signed_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[12] && instr[19:16] == 4'b1000) |=> out_undef);

   // R5
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[30]) |=> (out_result[63:32] == 32'h0));

   // R7
   undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_undef |-> (!out_wen && out_result == 64'h0));

   // R8
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> $onehot({out_wen, out_undef}));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_wen && !out_undef));

   // R8
   dest_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_rd == $past(instr[4:0]) && out_is64 == $past(instr[30])));

   // R9
   always_comb begin
      if (!rst_n) begin
         reset_clear_chk: assert (!out_wen && !out_undef && out_result == 64'h0);
      end
   end

endmodule

bind lane_extract_unit lx_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .instr      (instr),
   .out_wen    (out_wen),
   .out_undef  (out_undef),
   .out_result (out_result),
   .out_rd     (out_rd),
   .out_is64   (out_is64)
);

// File: tb/lane_extract_unit_tb_top.sv
module lane_extract_unit_tb_top;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [31:0]  instr;
   logic [127:0] vec_src;
   logic         out_wen;
   logic         out_undef;
   logic [63:0]  out_result;
   logic [4:0]   out_rd;
   logic         out_is64;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   lane_extract_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .instr      (instr),
      .vec_src    (vec_src),
      .out_wen    (out_wen),
      .out_undef  (out_undef),
      .out_result (out_result),
      .out_rd     (out_rd),
      .out_is64   (out_is64)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit q, input bit u, input logic [4:0] imm5,
                                      input logic [4:0] rn, input logic [4:0] rd);
      return {1'b0, q, 9'b001110000, imm5, 3'b001, u, 2'b11, rn, rd};
   endfunction

   function automatic void model(input logic [31:0] ins, input logic [127:0] v,
                                 output bit legal, output logic [63:0] res,
                                 output string req);
      bit hit;
      bit q;
      bit u;
      int sz;
      int w;
      int idx;
      logic [63:0] lane;
      bit sgn;
      hit = !ins[31] && ins[29:21] == 9'b001110000 && !ins[15] && !ins[14]
            && ins[13] && ins[11] && ins[10];
      q = ins[30];
      u = ins[12];
      sz = 4;
      for (int b = 3; b >= 0; b--) if (ins[16+b]) sz = b;
      legal = 1'b0;
      res   = 64'h0;
      if (!hit) begin
         req = "R1";
         return;
      end
      if (sz == 4) begin
         req = "R6";
         return;
      end
      w    = 8 << sz;
      idx  = int'(ins[20:16]) >> (sz + 1);
      lane = 64'(v >> (idx * w));
      if (w < 64) lane = lane & ((64'd1 << w) - 64'd1);
      sgn  = lane[w-1];
      if (u) begin
         req = "R3";
         if ((!q && sz < 3) || (q && sz == 3)) begin
            legal = 1'b1;
            res   = lane;
         end
      end else if (q) begin
         req = "R4";
         if (sz < 3) begin
            legal = 1'b1;
            res   = lane;
            if (sgn) res = res | ~((64'd1 << w) - 64'd1);
         end
      end else begin
         req = "R5";
         if (sz < 2) begin
            legal = 1'b1;
            res   = lane;
            if (sgn) res = res | (~((64'd1 << w) - 64'd1) & 64'h0000_0000_FFFF_FFFF);
         end
      end
   endfunction

   task automatic issue(input logic [31:0] ins, input logic [127:0] v);
      bit          legal;
      logic [63:0] exp;
      string       req;
      @(negedge clk);
      in_valid = 1'b1;
      instr    = ins;
      vec_src  = v;
      model(ins, v, legal, exp, req);
      @(posedge clk);
      #1;
      chk(out_wen == legal, req, "wen", 64'(out_wen), 64'(legal));
      chk(out_undef == !legal, {req, " R7"}, "undef", 64'(out_undef), 64'(!legal));
      chk(out_result == exp, {req, " R2"}, "result", out_result, exp);
      chk(out_rd == ins[4:0], "R8", "rd", 64'(out_rd), 64'(ins[4:0]));
      chk(out_is64 == ins[30], "R8", "is64", 64'(out_is64), 64'(ins[30]));
   endtask

   initial begin
      logic [127:0] vecs [3];
      logic [31:0]  base;
      int           flips [6];
      for (int k = 0; k < 16; k++) vecs[0][k*8 +: 8] = 8'(k * 29 + 147);
      vecs[1] = {128{1'b1}};
      vecs[2] = {8{16'h807f}};
      flips   = '{31, 29, 21, 15, 13, 10};

      rst_n    = 1'b0;
      in_valid = 1'b0;
      instr    = 32'h0;
      vec_src  = 128'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      chk(!out_wen && !out_undef, "R9", "flags", {62'h0, out_wen, out_undef}, 64'h0);
      chk(out_result == 64'h0, "R9", "result", out_result, 64'h0);
      chk(out_rd == 5'h0 && !out_is64, "R9", "dest", {58'h0, out_is64, out_rd}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: idle after reset
      chk(!out_wen && !out_undef, "R8", "idle", {62'h0, out_wen, out_undef}, 64'h0);

      for (int vi = 0; vi < 3; vi++)
         for (int q = 0; q < 2; q++)
            for (int u = 0; u < 2; u++)
               for (int im = 0; im < 32; im++)
                  issue(mk(q[0], u[0], 5'(im), 5'(~im), 5'(im ^ (vi * 7))), vecs[vi]);

      // R1: single-bit opcode corruptions of a legal word
      base = mk(1'b0, 1'b1, 5'b01011, 5'd3, 5'd9);
      issue(base, vecs[0]);
      foreach (flips[i]) issue(base ^ (32'd1 << flips[i]), vecs[0]);

      // R8: a cycle without issue after a legal issue
      issue(mk(1'b1, 1'b0, 5'b00001, 5'd1, 5'd17), vecs[2]);
      @(negedge clk);
      in_valid = 1'b0;
      instr    = mk(1'b1, 1'b0, 5'b00001, 5'd1, 5'd2);
      @(posedge clk);
      #1;
      chk(!out_wen && !out_undef, "R8", "no issue", {62'h0, out_wen, out_undef}, 64'h0);
      chk(out_rd == 5'd17, "R8", "rd held", 64'(out_rd), 64'd17);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule